// File: doc/BRIEF.md
# Seven-Bit Lane Packer and Serialiser

The block takes one pixel of 10-bit red, green and blue with a data-enable flag and two sync flags, spreads it across five 7-bit lane words, and shifts every lane out one bit per bit-time, most significant bit first. It runs on a fast clock, and an input enable pulse marks each bit-time. Seven enabled bit-times make one pixel period. A lane clock output runs beside the data. It is high for the first four bit-times of each pixel and low for the last three.

A mode input picks 8-bit colour, which uses only the upper eight bits of each component, or 10-bit colour, which also carries the two low bits. The data-enable flag and both sync flags always sit at fixed bit positions on lane 2.

Output control decides each cycle whether the lanes carry live data. They do so only when output-enable and link lock are both high. Otherwise a park select either drives every lane and the lane clock low, or drops the pad drive enable so that the pads float. The pad cells outside the block do the actual tri-stating.

Top module: `pixel_lane_packer`

## Requirements
- R1: After reset the bit slot counter stands at the last slot. Every seventh enabled bit-time starts a new pixel. During an enabled pixel period `lane_clk` is high for slots 0 to 3 and low for slots 4 to 6, where slot 0 carries word bit 6.
- R2: In slot k (k = 0 to 6) of a pixel, each lane shows bit 6−k of its word. The next pixel's bit 6 follows bit 0 on the very next enabled bit-time, with no idle slot in between.
- R3: Lane 2 bit 6 carries `pix_de`.
- R4: Lane 2 bit 5 carries `pix_vs` and lane 2 bit 4 carries `pix_hs`.
- R5: Form a 24-bit stream S = {blu[9:2], grn[9:2], red[9:2]}, most significant bit first. Lane 0 bits 6..0 carry S[6:0]. Lane 1 carries S[13:7]. Lane 2 bits 3..0 carry S[17:14]. Lane 3 bits 5..0 carry S[23:18]. When `wide_mode`=0 (8-bit), lane 3 bit 6 is 0 and lane 4 is all zero.
- R6: When `wide_mode`=1 (10-bit), form the group E = {blu[1:0], grn[1:0], red[1:0]}. Lane 3 bit 6 carries E[0], lane 4 bits 4..0 carry E[5:1], and lane 4 bits 6..5 are 0.
- R7: The pixel inputs and `wide_mode` are sampled only on the enabled bit-time that ends the previous pixel. Changes at any other time do not affect the word being sent.
- R8: When `out_en` and `link_lock` were both 1 at the previous clock edge, `lane_drv`=1 and the lanes and `lane_clk` show live data.
- R9: When outputs are disabled and `park_low`=1 at the previous edge, `lane_drv`=1 and all lanes and `lane_clk` are 0.
- R10: When outputs are disabled and `park_low`=0 at the previous edge, `lane_drv`=0 and all lanes and `lane_clk` are 0.
- R11: Synchronous reset clears all lane words, drops `lane_drv`, and makes the first enabled bit-time after reset load a pixel.
- R12: A clock edge with `bit_en`=0 changes neither the slot counter nor the lane words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks one bit-time |
| pix_red | input | 10 | Red component |
| pix_grn | input | 10 | Green component |
| pix_blu | input | 10 | Blue component |
| pix_de | input | 1 | Data-enable flag |
| pix_vs | input | 1 | Vertical sync flag |
| pix_hs | input | 1 | Horizontal sync flag |
| wide_mode | input | 1 | 1 = 10-bit colour, 0 = 8-bit colour |
| out_en | input | 1 | Output enable |
| link_lock | input | 1 | Upstream link locked |
| park_low | input | 1 | Disabled behaviour: 1 = drive low, 0 = float |
| lane_dat | output | 5 | Serial bit of each lane |
| lane_clk | output | 1 | Lane clock pattern |
| lane_drv | output | 1 | Pad drive enable |

## Verification
Every result of the block is due exactly one clock after the edge that sampled its cause. Serial bits and the lane clock move on the edge that sees `bit_en`. A new pixel word appears in slot 0 one edge after the load bit-time. The drive mode follows `out_en`, `link_lock` and `park_low` one edge later. The bench changes inputs on the falling edge, advances its own model for the coming rising edge, and compares all outputs at the next falling edge, so each check lands in the cycle the requirement names.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int LANE_W    = 7;
    localparam int COMP_W    = 10;
    localparam int HI_W      = 8;
    localparam int LO_W      = COMP_W - HI_W;
    localparam int NUM_LANES = 5;
    localparam int PHASE_W   = $clog2(LANE_W);
    localparam int CLK_HIGH  = 4;

    localparam int CTL_LANE  = 2;
    localparam int XTRA_LANE = 3;
    localparam int WIDE_LANE = 4;
    localparam int DE_BIT    = 6;
    localparam int VS_BIT    = 5;
    localparam int HS_BIT    = 4;

    localparam logic [PHASE_W-1:0] LAST_SLOT = PHASE_W'(LANE_W - 1);

    typedef logic [LANE_W-1:0]               lane_word_t;
    typedef lane_word_t [NUM_LANES-1:0]      lane_set_t;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
        logic              de;
        logic              vs;
        logic              hs;
    } pixel_t;

    typedef enum logic [1:0] {
        DRV_FLOAT = 2'd0,
        DRV_LOW   = 2'd1,
        DRV_DATA  = 2'd2
    } drive_e;

    // Spread one pixel over the lane words.
    function automatic lane_set_t pack_pixel(pixel_t px, logic wide);
        logic [3*HI_W-1:0] msb;
        logic [3*LO_W-1:0] lsb;
        lane_set_t         w;
        msb = {px.blu[COMP_W-1 -: HI_W], px.grn[COMP_W-1 -: HI_W], px.red[COMP_W-1 -: HI_W]};
        lsb = {px.blu[LO_W-1:0], px.grn[LO_W-1:0], px.red[LO_W-1:0]};
        w[0]         = msb[6:0];
        w[1]         = msb[13:7];
        w[CTL_LANE]  = {px.de, px.vs, px.hs, msb[17:14]};
        w[XTRA_LANE] = {wide & lsb[0], msb[23:18]};
        w[WIDE_LANE] = wide ? {2'b00, lsb[5:1]} : '0;
        return w;
    endfunction

    function automatic drive_e pick_drive(logic oe, logic lock, logic park);
        if (oe && lock) return DRV_DATA;
        if (park)       return DRV_LOW;
        return DRV_FLOAT;
    endfunction

endpackage

// File: rtl/lp_phase_ctr.sv
module lp_phase_ctr
    import lp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    output logic [PHASE_W-1:0] phase_q,
    output logic               load_now,
    output logic               clk_pat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= LAST_SLOT;
        end else if (bit_en) begin
            phase_q <= (phase_q == LAST_SLOT) ? '0 : phase_q + PHASE_W'(1);
        end
    end

    assign load_now = bit_en && (phase_q == LAST_SLOT);
    assign clk_pat  = phase_q < PHASE_W'(CLK_HIGH);

endmodule

// File: rtl/lp_lane_shifter.sv
module lp_lane_shifter
    import lp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 load_now,
    input  lane_set_t            next_words,
    output lane_set_t            words_q,
    output logic [NUM_LANES-1:0] ser_bits
);

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else if (load_now) begin
            words_q <= next_words;
        end else if (bit_en) begin
            for (int i = 0; i < NUM_LANES; i++) begin
                words_q[i] <= {words_q[i][LANE_W-2:0], 1'b0};
            end
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_tap
        assign ser_bits[g] = words_q[g][LANE_W-1];
    end

endmodule

// File: rtl/lp_out_gate.sv
module lp_out_gate
    import lp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 out_en,
    input  logic                 link_lock,
    input  logic                 park_low,
    input  logic [NUM_LANES-1:0] ser_bits,
    input  logic                 clk_pat,
    output logic [NUM_LANES-1:0] lane_dat,
    output logic                 lane_clk,
    output logic                 lane_drv
);

    drive_e drive_q;

    always_ff @(posedge clk) begin
        if (rst) drive_q <= DRV_FLOAT;
        else     drive_q <= pick_drive(out_en, link_lock, park_low);
    end

    always_comb begin
        lane_drv = (drive_q != DRV_FLOAT);
        if (drive_q == DRV_DATA) begin
            lane_dat = ser_bits;
            lane_clk = clk_pat;
        end else begin
            lane_dat = '0;
            lane_clk = 1'b0;
        end
    end

endmodule

// File: rtl/pixel_lane_packer.sv
module pixel_lane_packer
    import lp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bit_en,
    input  logic [COMP_W-1:0]          pix_red,
    input  logic [COMP_W-1:0]          pix_grn,
    input  logic [COMP_W-1:0]          pix_blu,
    input  logic                       pix_de,
    input  logic                       pix_vs,
    input  logic                       pix_hs,
    input  logic                       wide_mode,
    input  logic                       out_en,
    input  logic                       link_lock,
    input  logic                       park_low,
    output logic [NUM_LANES-1:0]       lane_dat,
    output logic                       lane_clk,
    output logic                       lane_drv
);

    pixel_t               px;
    lane_set_t            next_words;
    lane_set_t            words_q;
    logic [PHASE_W-1:0]   phase_q;
    logic                 load_now;
    logic                 clk_pat;
    logic [NUM_LANES-1:0] ser_bits;

    assign px = '{red: pix_red, grn: pix_grn, blu: pix_blu,
                  de: pix_de, vs: pix_vs, hs: pix_hs};
    assign next_words = pack_pixel(px, wide_mode);

    lp_phase_ctr u_phase (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .phase_q  (phase_q),
        .load_now (load_now),
        .clk_pat  (clk_pat)
    );

    lp_lane_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .load_now   (load_now),
        .next_words (next_words),
        .words_q    (words_q),
        .ser_bits   (ser_bits)
    );

    lp_out_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .out_en    (out_en),
        .link_lock (link_lock),
        .park_low  (park_low),
        .ser_bits  (ser_bits),
        .clk_pat   (clk_pat),
        .lane_dat  (lane_dat),
        .lane_clk  (lane_clk),
        .lane_drv  (lane_drv)
    );

endmodule

// File: rtl/lp_checker.sv
module lp_checker
    import lp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 pix_de,
    input  logic                 pix_vs,
    input  logic                 pix_hs,
    input  logic                 wide_mode,
    input  logic                 out_en,
    input  logic                 link_lock,
    input  logic                 park_low,
    input  logic [NUM_LANES-1:0] lane_dat,
    input  logic                 lane_clk,
    input  logic                 lane_drv,
    input  logic [PHASE_W-1:0]   phase_q,
    input  lane_set_t            words_q
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        bit_en && phase_q == LAST_SLOT |=> phase_q == '0);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(phase_q) && $stable(words_q));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        p_shift_r2: assert property (@(posedge clk) disable iff (rst)
            bit_en && phase_q != LAST_SLOT |=>
                words_q[g][LANE_W-1:1] == $past(words_q[g][LANE_W-2:0]) && !words_q[g][0]);
    end

    p_de_slot_r3: assert property (@(posedge clk) disable iff (rst)
        bit_en && phase_q == LAST_SLOT |=> words_q[CTL_LANE][DE_BIT] == $past(pix_de));

    p_sync_slot_r4: assert property (@(posedge clk) disable iff (rst)
        bit_en && phase_q == LAST_SLOT |=>
            words_q[CTL_LANE][VS_BIT] == $past(pix_vs) && words_q[CTL_LANE][HS_BIT] == $past(pix_hs));

    p_narrow_zero_r5: assert property (@(posedge clk) disable iff (rst)
        bit_en && phase_q == LAST_SLOT && !wide_mode |=>
            !words_q[XTRA_LANE][LANE_W-1] && words_q[WIDE_LANE] == '0);

    p_live_r8: assert property (@(posedge clk) disable iff (rst)
        armed && $past(out_en && link_lock) |->
            lane_drv && lane_clk == (phase_q < PHASE_W'(CLK_HIGH)));

    p_park_low_r9: assert property (@(posedge clk) disable iff (rst)
        armed && $past(!(out_en && link_lock) && park_low) |->
            lane_drv && lane_dat == '0 && !lane_clk);

    p_float_r10: assert property (@(posedge clk) disable iff (rst)
        armed && $past(!(out_en && link_lock) && !park_low) |->
            !lane_drv && lane_dat == '0 && !lane_clk);

endmodule

bind pixel_lane_packer lp_checker u_lp_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .pix_de    (pix_de),
    .pix_vs    (pix_vs),
    .pix_hs    (pix_hs),
    .wide_mode (wide_mode),
    .out_en    (out_en),
    .link_lock (link_lock),
    .park_low  (park_low),
    .lane_dat  (lane_dat),
    .lane_clk  (lane_clk),
    .lane_drv  (lane_drv),
    .phase_q   (phase_q),
    .words_q   (words_q)
);

// File: tb/tb_pixel_lane_packer.sv
module tb_pixel_lane_packer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [9:0] r = '0, g = '0, b = '0;
    logic       de = 1'b0, vs = 1'b0, hs = 1'b0;
    logic       wide = 1'b0, oe = 1'b0, lock = 1'b0, park = 1'b0;
    wire  [4:0] lane_dat;
    wire        lane_clk, lane_drv;

    int n_chk = 0;
    int n_fail = 0;

    int              mphase = 6;
    logic [4:0][6:0] mw = '0;
    logic            mwide = 1'b0;
    int              mgate = 0;
    int              prev_gate = 0;
    logic            prev_en = 1'b0;
    string           tag_ovr = "";

    always #5 clk = ~clk;

    pixel_lane_packer dut (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .pix_red(r), .pix_grn(g), .pix_blu(b),
        .pix_de(de), .pix_vs(vs), .pix_hs(hs),
        .wide_mode(wide), .out_en(oe), .link_lock(lock), .park_low(park),
        .lane_dat(lane_dat), .lane_clk(lane_clk), .lane_drv(lane_drv)
    );

    function automatic logic [4:0][6:0] ref_words(logic [9:0] rr, logic [9:0] gg, logic [9:0] bb,
                                                  logic d, logic v, logic h, logic w);
        logic [23:0]     s;
        logic [5:0]      e;
        logic [4:0][6:0] o;
        s = {bb[9:2], gg[9:2], rr[9:2]};
        e = {bb[1:0], gg[1:0], rr[1:0]};
        o[0] = s[6:0];
        o[1] = s[13:7];
        o[2] = {d, v, h, s[17:14]};
        o[3] = {w ? e[0] : 1'b0, s[23:18]};
        o[4] = w ? {2'b00, e[5:1]} : 7'd0;
        return o;
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string data_tag(int l);
        if (tag_ovr != "") return tag_ovr;
        if (mgate == 0) return "R10";
        if (mgate == 1) return "R9";
        if (prev_gate != 2) return "R8";
        if (!prev_en) return "R12";
        if (l == 2 && mphase == 0) return "R3";
        if (l == 2 && (mphase == 1 || mphase == 2)) return "R4";
        if ((l == 3 && mphase == 0) || l == 4) return mwide ? "R6" : "R5";
        return "R2";
    endfunction

    task automatic check_all();
        logic expb;
        for (int l = 0; l < 5; l++) begin
            expb = (mgate == 2) ? mw[l][6-mphase] : 1'b0;
            chk(data_tag(l), $sformatf("lane%0d slot%0d", l, mphase), {7'd0, lane_dat[l]}, {7'd0, expb});
        end
        chk((mgate == 2) ? "R1" : (mgate == 1 ? "R9" : "R10"), "lane_clk",
            {7'd0, lane_clk}, {7'd0, (mgate == 2) && (mphase < 4)});
        chk((mgate == 2) ? "R8" : (mgate == 1 ? "R9" : "R10"), "lane_drv",
            {7'd0, lane_drv}, {7'd0, mgate != 0});
    endtask

    // Advance the model for the coming rising edge, then compare at the next falling edge.
    task automatic tick();
        prev_en   = bit_en;
        prev_gate = mgate;
        if (rst) begin
            mphase = 6; mw = '0; mgate = 0;
        end else begin
            if (bit_en) begin
                if (mphase == 6) begin
                    mphase = 0;
                    mw     = ref_words(r, g, b, de, vs, hs, wide);
                    mwide  = wide;
                end else begin
                    mphase++;
                end
            end
            mgate = (oe && lock) ? 2 : (park ? 1 : 0);
        end
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic rnd_pix();
        r = 10'($urandom); g = 10'($urandom); b = 10'($urandom);
        de = 1'($urandom); vs = 1'($urandom); hs = 1'($urandom);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        @(negedge clk);
        // R11: reset state
        tag_ovr = "R11";
        repeat (3) tick();
        rst = 1'b0; oe = 1'b1; lock = 1'b1; bit_en = 1'b1;
        r = 10'h3FF; g = 10'h000; b = 10'h2AA; de = 1'b1; vs = 1'b0; hs = 1'b1;
        repeat (8) tick();
        tag_ovr = "";
        // 8-bit directed patterns, then 10-bit
        r = 10'h155; g = 10'h0F3; b = 10'h3C6; de = 1'b0; vs = 1'b1; hs = 1'b0;
        repeat (14) tick();
        wide = 1'b1; r = 10'h001; g = 10'h002; b = 10'h3FF; de = 1'b1; vs = 1'b1; hs = 1'b1;
        repeat (14) tick();
        // R7: inputs change every cycle, only load-time values count
        tag_ovr = "R7";
        for (int i = 0; i < 35; i++) begin
            rnd_pix();
            wide = 1'($urandom);
            tick();
        end
        tag_ovr = "";
        // R12: sparse bit enables
        for (int i = 0; i < 60; i++) begin
            bit_en = ($urandom % 4) == 0;
            rnd_pix();
            tick();
        end
        // R8 R9 R10: output control sweep
        bit_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            oe = i[0]; lock = i[1]; park = i[2];
            repeat (5) tick();
        end
        // Mixed random run
        for (int i = 0; i < 3000; i++) begin
            bit_en = ($urandom % 4) != 0;
            rnd_pix();
            if ($urandom % 32 == 0) wide = ~wide;
            if ($urandom % 20 == 0) begin
                oe = ($urandom % 4) != 0; lock = ($urandom % 4) != 0; park = 1'($urandom);
            end
            tick();
        end
        // R11: reset in mid stream
        tag_ovr = "R11";
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0; oe = 1'b1; lock = 1'b1; bit_en = 1'b1;
        repeat (9) tick();
        tag_ovr = "";
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule